// File: doc/BRIEF.md
# UART Packet Receiver with Idle Timeout

This block receives asynchronous serial bytes and collects them into variable-length packets. Each frame has one low start bit, eight data bits sent least significant bit first, and one high stop bit. The receiver writes each good byte straight into a linear packet store, and a consumer reads the store by address.

A packet closes in one of two ways. The first is a carriage-return byte. The second is a quiet line: a millisecond counter runs only while a packet is open, restarts on every received byte, and closes the packet once it passes a programmed limit. The consumer reads the length and the bytes, then pulses a done strobe. That empties the store and returns the block to idle. A flush request throws away the frame that is being received, so that byte never reaches the store.

The read side is a plain random-access port with no handshake. Back-pressure takes the form of freezing. While a packet is marked complete, the store, the length and the byte order do not change, and bytes that arrive are dropped. The consumer may read at any pace until it pulses done.

Top module: `uart_pkt_rx`

## Requirements
- R1: Frames are 1 low start bit, 8 data bits LSB first and 1 high stop bit. The k-th good byte of a packet (k from 0) is readable at `rd_addr_i` = k, and `pkt_len_o` counts the stored bytes.
- R2: One bit lasts `baud_div_i` clocks. A start is only confirmed if the line is still low half a bit period after the falling edge, so a shorter low glitch stores nothing.
- R3: A frame whose stop bit samples low is not stored, and `frame_err_o` is high for exactly one clock.
- R4: After the last byte, `pkt_complete_o` rises once the number of 1 ms ticks exceeds `timeout_ms_i`. It stays low until at least `timeout_ms_i` ms have passed.
- R5: The idle counter only advances while a packet is open. With no byte received since reset or since the last done, `pkt_complete_o` stays low however long the line is idle.
- R6: A received byte 0x0D closes the packet at once. It is not stored and is not counted in `pkt_len_o`.
- R7: While `pkt_complete_o` is high, received bytes are dropped, and the length and the stored bytes stay unchanged.
- R8: A one-cycle `pkt_done_i` sets `pkt_len_o` to 0 and clears `pkt_complete_o` and `overflow_o` on the next clock.
- R9: A byte that arrives when the store holds DEPTH bytes is dropped, and it sets `overflow_o`. That flag stays high until `pkt_done_i`.
- R10: A `flush_i` pulse during a frame discards that frame's byte. The length stays the same and the idle counter is not restarted. The next frame is received normally.
- R11: After reset, `pkt_len_o` is 0 and `pkt_complete_o`, `overflow_o` and `frame_err_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_i | input | 1 | Serial receive line, idle high |
| baud_div_i | input | DIV_W | Clocks per bit |
| timeout_ms_i | input | TMO_W | Idle limit in milliseconds |
| flush_i | input | 1 | Discard the frame in progress |
| pkt_done_i | input | 1 | Consumer finished; empty the store |
| rd_addr_i | input | AW | Read address into the packet store |
| rd_data_o | output | 8 | Byte at `rd_addr_i` (combinational) |
| pkt_len_o | output | LW | Bytes stored in the current packet |
| pkt_complete_o | output | 1 | Packet closed by terminator or timeout |
| frame_err_o | output | 1 | One-clock pulse on a bad stop bit |
| overflow_o | output | 1 | Sticky: a byte was lost to a full store |

## Verification
Two situations are hard to reach from the ports. The first is a flush that lands while a frame is still on the wire. The bench forks the serial driver and the flush pulse, so the request arrives mid-byte. It then shows that the discarded byte neither changed the length nor started the idle counter. The second is the idle timeout. Its exact edge depends on the phase of the free-running millisecond tick, so the bench samples well inside the early and late bounds rather than at one cycle.

// File: rtl/uart_pkt_pkg.sv
package uart_pkt_pkg;
  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rx_state_e;

  localparam logic [7:0] TERM_BYTE = 8'h0D;
endpackage

// File: rtl/uart_ms_tick.sv
module uart_ms_tick #(
  parameter int TICK_CYC = 1000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int TW = (TICK_CYC > 1) ? $clog2(TICK_CYC) : 1;
  localparam logic [TW-1:0] LAST = TW'(TICK_CYC - 1);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else if (cnt_q == LAST) begin
      cnt_q  <= '0;
      tick_o <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
      tick_o <= 1'b0;
    end
  end

  generate
    if (TICK_CYC > 1) begin : g_tick_chk
      // R4: the millisecond tick is a single-cycle pulse
      a_r4_tick_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/uart_rx_deser.sv
module uart_rx_deser
  import uart_pkt_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             flush_i,
  output logic [7:0]       byte_o,
  output logic             byte_vld_o,
  output logic             frame_err_o
);
  logic [1:0]       sync_q;
  logic             rx_s;
  rx_state_e        state_q;
  logic [DIV_W-1:0] cnt_q;
  logic [2:0]       bit_q;
  logic             discard_q;
  logic [DIV_W-1:0] half_end;
  logic [DIV_W-1:0] bit_end;

  assign rx_s     = sync_q[1];
  assign half_end = ((div_i >> 1) == '0) ? '0 : (div_i >> 1) - 1'b1;
  assign bit_end  = (div_i == '0) ? '0 : div_i - 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b11;
    else        sync_q <= {sync_q[0], rx_i};
  end

  // remembers a flush seen during the current frame
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  discard_q <= 1'b0;
    else if (state_q == RX_IDLE) discard_q <= 1'b0;
    else if (flush_i)            discard_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= RX_IDLE;
      cnt_q       <= '0;
      bit_q       <= '0;
      byte_o      <= '0;
      byte_vld_o  <= 1'b0;
      frame_err_o <= 1'b0;
    end else begin
      byte_vld_o  <= 1'b0;
      frame_err_o <= 1'b0;
      unique case (state_q)
        RX_IDLE: begin
          cnt_q <= '0;
          if (!rx_s) state_q <= RX_START;
        end
        RX_START: begin
          if (cnt_q == half_end) begin
            cnt_q <= '0;
            bit_q <= '0;
            state_q <= rx_s ? RX_IDLE : RX_DATA;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        RX_DATA: begin
          if (cnt_q == bit_end) begin
            cnt_q  <= '0;
            byte_o <= {rx_s, byte_o[7:1]};
            if (bit_q == 3'd7) state_q <= RX_STOP;
            bit_q <= bit_q + 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        RX_STOP: begin
          if (cnt_q == bit_end) begin
            cnt_q   <= '0;
            state_q <= RX_IDLE;
            if (rx_s) byte_vld_o  <= ~(discard_q | flush_i);
            else      frame_err_o <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= RX_IDLE;
      endcase
    end
  end

  // R1: a finished byte is presented for one cycle only
  a_r1_vld_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld_o |=> !byte_vld_o);
  // R3: framing error is a single-cycle pulse
  a_r3_ferr_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err_o |=> !frame_err_o);
  // R3: a bad stop never also yields a byte
  a_r3_ferr_no_byte: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_err_o && byte_vld_o));
endmodule

// File: rtl/uart_pkt_store.sv
module uart_pkt_store
  import uart_pkt_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int TMO_W = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       byte_i,
  input  logic             byte_vld_i,
  input  logic             tick_i,
  input  logic [TMO_W-1:0] tmo_thr_i,
  input  logic             pkt_done_i,
  input  logic [AW-1:0]    rd_addr_i,
  output logic [7:0]       rd_data_o,
  output logic [LW-1:0]    len_o,
  output logic             complete_o,
  output logic             overflow_o
);
  localparam logic [LW-1:0] FULL_LEN = LW'(DEPTH);
  localparam logic [AW:0]   DEPTH_V  = (AW + 1)'(DEPTH);

  logic [7:0]       mem [DEPTH];
  logic [TMO_W-1:0] idle_q;
  logic             busy_q;
  logic             accept;
  logic             is_term;
  logic             full;
  logic             wr_en;
  logic [TMO_W:0]   idle_nx;

  assign accept  = byte_vld_i && !complete_o && !pkt_done_i;
  assign is_term = (byte_i == TERM_BYTE);
  assign full    = (len_o == FULL_LEN);
  assign wr_en   = accept && !is_term && !full;
  assign idle_nx = {1'b0, idle_q} + 1'b1;

  always_ff @(posedge clk) begin
    if (wr_en) mem[len_o[AW-1:0]] <= byte_i;
  end

  assign rd_data_o = ({1'b0, rd_addr_i} < DEPTH_V) ? mem[rd_addr_i] : 8'h00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_o      <= '0;
      complete_o <= 1'b0;
      overflow_o <= 1'b0;
      busy_q     <= 1'b0;
      idle_q     <= '0;
    end else if (pkt_done_i) begin
      len_o      <= '0;
      complete_o <= 1'b0;
      overflow_o <= 1'b0;
      busy_q     <= 1'b0;
      idle_q     <= '0;
    end else if (accept) begin
      busy_q <= 1'b1;
      idle_q <= '0;
      if (is_term)   complete_o <= 1'b1;
      else if (full) overflow_o <= 1'b1;
      else           len_o <= len_o + 1'b1;
    end else if (tick_i && busy_q && !complete_o) begin
      if (idle_nx > {1'b0, tmo_thr_i}) complete_o <= 1'b1;
      else                             idle_q <= idle_nx[TMO_W-1:0];
    end
  end

  // R1: length never passes the store depth
  a_r1_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
    len_o <= FULL_LEN);
  // R7: a closed packet is frozen until the consumer is done
  a_r7_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (complete_o && !pkt_done_i) |=> ($stable(len_o) && complete_o));
  // R8: done empties the packet
  a_r8_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_done_i |=> (len_o == '0 && !complete_o && !overflow_o));
  // R9: overflow holds until done
  a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow_o && !pkt_done_i) |=> overflow_o);
  // R5: without an open packet the timeout cannot close one
  a_r5_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && !byte_vld_i && !complete_o) |=> !complete_o);
endmodule

// File: rtl/uart_pkt_rx.sv
module uart_pkt_rx #(
  parameter int CLK_HZ = 50_000_000,
  parameter int DEPTH  = 16,
  parameter int DIV_W  = 16,
  parameter int TMO_W  = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_i,
  input  logic [DIV_W-1:0] baud_div_i,
  input  logic [TMO_W-1:0] timeout_ms_i,
  input  logic             flush_i,
  input  logic             pkt_done_i,
  input  logic [AW-1:0]    rd_addr_i,
  output logic [7:0]       rd_data_o,
  output logic [LW-1:0]    pkt_len_o,
  output logic             pkt_complete_o,
  output logic             frame_err_o,
  output logic             overflow_o
);
  localparam int TICK_CYC = (CLK_HZ / 1000 > 0) ? CLK_HZ / 1000 : 1;

  logic       tick;
  logic [7:0] rx_byte;
  logic       rx_vld;

  uart_ms_tick #(.TICK_CYC(TICK_CYC)) u_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_o (tick)
  );

  uart_rx_deser #(.DIV_W(DIV_W)) u_deser (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_i        (rx_i),
    .div_i       (baud_div_i),
    .flush_i     (flush_i),
    .byte_o      (rx_byte),
    .byte_vld_o  (rx_vld),
    .frame_err_o (frame_err_o)
  );

  uart_pkt_store #(.DEPTH(DEPTH), .TMO_W(TMO_W)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .byte_i     (rx_byte),
    .byte_vld_i (rx_vld),
    .tick_i     (tick),
    .tmo_thr_i  (timeout_ms_i),
    .pkt_done_i (pkt_done_i),
    .rd_addr_i  (rd_addr_i),
    .rd_data_o  (rd_data_o),
    .len_o      (pkt_len_o),
    .complete_o (pkt_complete_o),
    .overflow_o (overflow_o)
  );
endmodule

// File: tb/sim_uart_pkt_rx.sv
module sim_uart_pkt_rx;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_HZ = 100_000;
  localparam int DEPTH = 8;
  localparam int DIV = 16;
  localparam int TMO = 3;
  localparam int AW = $clog2(DEPTH);
  localparam int LW = $clog2(DEPTH + 1);
  localparam int NVEC = 6;
  // {stop_ok, data, expected length after the frame}
  localparam logic [16:0] VEC [NVEC] = '{
    {1'b1, 8'hA5, 8'd1}, {1'b1, 8'h3C, 8'd2}, {1'b0, 8'h77, 8'd2},
    {1'b1, 8'h00, 8'd3}, {1'b1, 8'hFF, 8'd4}, {1'b1, 8'h81, 8'd5}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx = 1'b1;
  logic flush = 1'b0;
  logic done = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic [LW-1:0] len;
  logic complete, ferr, ovf;
  int checks = 0;
  int fails = 0;
  int ferr_cnt = 0;
  bit finished = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  uart_pkt_rx #(.CLK_HZ(CLK_HZ), .DEPTH(DEPTH), .DIV_W(16), .TMO_W(16)) u0 (
    .clk(clk), .rst_n(rst_n), .rx_i(rx), .baud_div_i(16'(DIV)),
    .timeout_ms_i(16'(TMO)), .flush_i(flush), .pkt_done_i(done),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .pkt_len_o(len),
    .pkt_complete_o(complete), .frame_err_o(ferr), .overflow_o(ovf)
  );

  always @(posedge clk) if (ferr) ferr_cnt <= ferr_cnt + 1;

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic send(input logic [7:0] b, input logic stop_ok);
    @(negedge clk) rx = 1'b0;
    repeat (DIV) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rx = b[i];
      repeat (DIV) @(negedge clk);
    end
    rx = stop_ok;
    repeat (DIV) @(negedge clk);
    rx = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic pulse_done();
    @(negedge clk) done = 1'b1;
    @(negedge clk) done = 1'b0;
    @(negedge clk);
  endtask

  task automatic read_at(input int a, output logic [7:0] d);
    @(negedge clk) rd_addr = AW'(a);
    #1 d = rd_data;
  endtask

  initial begin
    logic [7:0] d;
    int fe0;
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 len", 32'(len), 0);
    check("R11 flags", {29'd0, complete, ovf, ferr}, 0);
    rst_n = 1'b1;
    // R5: long quiet line with nothing open
    repeat (1000) @(negedge clk);
    check("R5 no packet on idle", 32'(complete), 0);

    // R1 / R3 table walk
    for (int i = 0; i < NVEC; i++) begin
      fe0 = ferr_cnt;
      send(VEC[i][15:8], VEC[i][16]);
      check("R1 length", 32'(len), 32'(VEC[i][7:0]));
      if (VEC[i][16]) begin
        read_at(int'(VEC[i][7:0]) - 1, d);
        check("R1 data", 32'(d), 32'(VEC[i][15:8]));
      end else begin
        check("R3 ferr pulse", 32'(ferr_cnt - fe0), 1);
      end
    end
    // R4 timeout window
    repeat (250) @(negedge clk);
    check("R4 not early", 32'(complete), 0);
    repeat (250) @(negedge clk);
    check("R4 closed", 32'(complete), 1);
    // R7 frozen while complete
    send(8'h42, 1'b1);
    check("R7 len frozen", 32'(len), 5);
    read_at(0, d);
    check("R7 data kept", 32'(d), 32'h A5);
    // R8 done clears
    pulse_done();
    check("R8 len cleared", 32'(len), 0);
    check("R8 complete cleared", 32'(complete), 0);
    repeat (600) @(negedge clk);
    check("R5 stays idle after done", 32'(complete), 0);

    // R6 terminator
    send(8'h41, 1'b1);
    send(8'h42, 1'b1);
    send(8'h0D, 1'b1);
    check("R6 complete on CR", 32'(complete), 1);
    check("R6 len excludes CR", 32'(len), 2);
    read_at(1, d);
    check("R6 data", 32'(d), 32'h42);
    pulse_done();

    // R10 flush mid-frame
    fork
      send(8'h55, 1'b1);
      begin
        repeat (40) @(negedge clk);
        flush = 1'b1;
        @(negedge clk) flush = 1'b0;
      end
    join
    check("R10 flushed not stored", 32'(len), 0);
    repeat (600) @(negedge clk);
    check("R10 no timeout started", 32'(complete), 0);
    send(8'h66, 1'b1);
    check("R10 next byte stored", 32'(len), 1);
    read_at(0, d);
    check("R10 next data", 32'(d), 32'h66);
    pulse_done();

    // R2 short glitch
    fe0 = ferr_cnt;
    @(negedge clk) rx = 1'b0;
    repeat (DIV / 2 - 2) @(negedge clk);
    rx = 1'b1;
    repeat (200) @(negedge clk);
    check("R2 glitch ignored", 32'(len), 0);
    check("R2 glitch no ferr", 32'(ferr_cnt - fe0), 0);

    // R9 overflow
    for (int i = 0; i < DEPTH + 1; i++) send(8'(8'h10 + i), 1'b1);
    check("R9 len full", 32'(len), DEPTH);
    check("R9 overflow set", 32'(ovf), 1);
    read_at(DEPTH - 1, d);
    check("R9 last kept", 32'(d), 32'(8'h10 + DEPTH - 1));
    repeat (20) @(negedge clk);
    check("R9 overflow sticky", 32'(ovf), 1);
    pulse_done();
    check("R8 overflow cleared", 32'(ovf), 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule